// File: doc/BRIEF.md
# Address-Windowed SECDED Guard for a Memory Data Path

This block sits between the write and read data paths of a memory controller and the data and check lanes of an SDRAM bus. Any write whose address lies inside a programmable window gets check bits computed from its data. Any read inside that window has its check bits compared with the data, so that a single flipped bit is repaired and a double flip is reported. Traffic outside the window passes straight through with an all-zero check lane and no checking.

A mode input selects between a 32-bit protected word, which carries 7 check bits, and a 16-bit protected word, which carries 6 check bits. Both codes are a Hamming code extended with one overall parity bit, and both ride on the same 8-bit check lane. Two saturating event counters, one for repaired words and one for unrepairable words, and a latch that holds the address of the first unrepairable read are reached through a small register port. Software clears them with write-one-to-clear bits.

Top module: `eccSecdedGuard`

## Requirements
- R1: In wide mode (narrowMode=0) a protected write drives lane bits [5:0] with Hamming bits, lane bit 6 with even overall parity over the 32 data bits and the six Hamming bits, and lane bit 7 with zero. Hamming bit i is the XOR of the data bits whose codeword position has bit i set. Codeword positions start at 1, and data bit k sits at the k-th position that is not a power of two.
- R2: In narrow mode (narrowMode=1) only data[15:0] is coded, using the same position rule. Lane bits [4:0] carry the Hamming bits, lane bit 5 carries the overall parity and lane bits [7:6] are zero. data[31:16] passes through in both directions without coding or checking.
- R3: A protected read with exactly one flipped bit, whether in the data, a Hamming bit or the overall parity bit, returns the original data with singleErr=1 and doubleErr=0.
- R4: A protected read with two flipped bits returns doubleErr=1 and singleErr=0. A syndrome that points beyond the last codeword position is also reported as doubleErr.
- R5: An access is protected when winStart <= address <= winEnd. An unprotected write drives a zero check lane. An unprotected read returns its data unchanged with both error flags low.
- R6: Lane bit 7 in wide mode, and lane bits [7:6] in narrow mode, are ignored on reads.
- R7: The repaired-word counter and the unrepairable-word counter count separately, each once per flagged read, and each holds at all-ones once it gets there.
- R8: The register port maps 0 to winStart, 1 to winEnd, 2 to the repaired count, 3 to the unrepairable count and 4 to the failure address. A write to address 5 clears the repaired count (bit 0), the unrepairable count (bit 1) and the failure latch (bit 2). A clear takes effect over an event in the same cycle.
- R9: The first unrepairable read latches its address and sets errLatched. Later unrepairable reads leave the latched address unchanged until bit 2 clear.
- R10: memValid, memData and memCheck follow a write one clock later. outValid, outData and the error flags follow a read one clock later. The counters and the latch move one clock after the flags.
- R11: After reset winStart is all-ones, winEnd is zero (nothing is protected), both counters are zero, errLatched is low and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| narrowMode | input | 1 | 1 selects 16-bit coding, 0 selects 32-bit coding |
| wrValid | input | 1 | Write beat present |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 32 | Write data |
| memValid | output | 1 | Beat toward memory valid |
| memData | output | 32 | Data toward memory |
| memCheck | output | 8 | Check lane toward memory |
| rdValid | input | 1 | Read beat present |
| rdAddr | input | ADDR_W | Read address |
| rdData | input | 32 | Data from memory |
| rdCheck | input | 8 | Check lane from memory |
| outValid | output | 1 | Returned read beat valid |
| outData | output | 32 | Corrected read data |
| singleErr | output | 1 | Beat was repaired |
| doubleErr | output | 1 | Beat is unrepairable |
| cfgWrite | input | 1 | Register write strobe |
| cfgAddr | input | 3 | Register select |
| cfgWdata | input | ADDR_W | Register write data |
| cfgRdata | output | ADDR_W | Register read data (combinational) |
| errLatched | output | 1 | A failure address is held |

## Verification
On every cycle the assertions check the following. The unused lane bits stay zero. The two error flags are never raised together and appear only with outValid. Unprotected beats keep their data and carry neither check bits nor flags. The counters move only by one step or by a clear, and never wrap. The latched address stays fixed while the latch is set. Whether the check bits are the right code, whether a given flip is repaired, and whether the window edges are inclusive can only be shown by the bench. Its scenarios compare each encoded lane with an independent model and inject chosen flips into data and lane bits in both modes.

// File: rtl/eccSecdedPkg.sv
package eccSecdedPkg;

  localparam int DATA_W          = 32;
  localparam int LANE_W          = 8;
  localparam int NARROW_DATA_W   = 16;
  localparam int WIDE_HAM_W      = 6;
  localparam int NARROW_HAM_W    = 5;
  localparam int WIDE_LAST_POS   = DATA_W + WIDE_HAM_W;           // 38
  localparam int NARROW_LAST_POS = NARROW_DATA_W + NARROW_HAM_W;  // 21

  // strobes from control to datapath
  typedef struct packed {
    logic wrProtect;
    logic rdProtect;
    logic narrow;
  } eccStrobe_t;

  function automatic logic isPow2(int p);
    return (p & (p - 1)) == 0;
  endfunction

  // Hamming bits over the coded data bits; unused top bit stays zero in narrow mode
  function automatic logic [WIDE_HAM_W-1:0] hamBits(logic [DATA_W-1:0] d, logic narrow);
    logic [WIDE_HAM_W-1:0] c;
    int idx;
    int lastPos;
    c = '0;
    idx = 0;
    lastPos = narrow ? NARROW_LAST_POS : WIDE_LAST_POS;
    for (int pos = 1; pos <= WIDE_LAST_POS; pos++) begin
      if (pos <= lastPos && !isPow2(pos)) begin
        for (int b = 0; b < WIDE_HAM_W; b++) begin
          if (pos[b]) c[b] = c[b] ^ d[idx[4:0]];
        end
        idx++;
      end
    end
    return c;
  endfunction

  // invert the data bit that sits at codeword position syn
  function automatic logic [DATA_W-1:0] flipAt(logic [DATA_W-1:0] d, logic [WIDE_HAM_W-1:0] syn,
                                               logic narrow);
    logic [DATA_W-1:0] r;
    int idx;
    int lastPos;
    r = d;
    idx = 0;
    lastPos = narrow ? NARROW_LAST_POS : WIDE_LAST_POS;
    for (int pos = 1; pos <= WIDE_LAST_POS; pos++) begin
      if (pos <= lastPos && !isPow2(pos)) begin
        if (pos == int'(syn)) r[idx[4:0]] = ~r[idx[4:0]];
        idx++;
      end
    end
    return r;
  endfunction

  function automatic logic dataParity(logic [DATA_W-1:0] d, logic narrow);
    return narrow ? ^d[NARROW_DATA_W-1:0] : ^d;
  endfunction

  function automatic logic [LANE_W-1:0] encodeLane(logic [DATA_W-1:0] d, logic narrow);
    logic [WIDE_HAM_W-1:0] h;
    logic ovr;
    h = hamBits(d, narrow);
    ovr = dataParity(d, narrow) ^ (^h);
    return narrow ? {2'b00, ovr, h[NARROW_HAM_W-1:0]} : {1'b0, ovr, h};
  endfunction

endpackage

// File: rtl/eccSatCounter.sv
module eccSatCounter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    count <= '0;
    else if (clr)                 count <= '0;
    else if (inc && count != '1)  count <= count + 1'b1;
  end
endmodule

// File: rtl/eccControl.sv
module eccControl
  import eccSecdedPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              narrowMode,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              cfgWrite,
  input  logic [2:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  input  logic              evtValid,
  input  logic              evtSingle,
  input  logic              evtDouble,
  input  logic [ADDR_W-1:0] evtAddr,
  output eccStrobe_t        strobe,
  output logic [CNT_W-1:0]  sglCount,
  output logic [CNT_W-1:0]  dblCount,
  output logic              errLatched,
  output logic [ADDR_W-1:0] failAddr
);
  localparam logic [2:0] SEL_START = 3'd0;
  localparam logic [2:0] SEL_END   = 3'd1;
  localparam logic [2:0] SEL_SGL   = 3'd2;
  localparam logic [2:0] SEL_DBL   = 3'd3;
  localparam logic [2:0] SEL_FAIL  = 3'd4;
  localparam logic [2:0] SEL_CLEAR = 3'd5;

  logic [ADDR_W-1:0] winStart, winEnd;
  logic clrSgl, clrDbl, clrFail;
  logic [ADDR_W-1:0] sglWide, dblWide;

  assign strobe.wrProtect = wrValid && (wrAddr >= winStart) && (wrAddr <= winEnd);
  assign strobe.rdProtect = rdValid && (rdAddr >= winStart) && (rdAddr <= winEnd);
  assign strobe.narrow    = narrowMode;

  wire clearHit = cfgWrite && (cfgAddr == SEL_CLEAR);
  assign clrSgl  = clearHit && cfgWdata[0];
  assign clrDbl  = clearHit && cfgWdata[1];
  assign clrFail = clearHit && cfgWdata[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winStart <= '1;
      winEnd   <= '0;
    end else if (cfgWrite) begin
      if (cfgAddr == SEL_START) winStart <= cfgWdata;
      if (cfgAddr == SEL_END)   winEnd   <= cfgWdata;
    end
  end

  eccSatCounter #(.CNT_W(CNT_W)) uSglCnt (
    .clk(clk), .rstN(rstN), .clr(clrSgl), .inc(evtValid && evtSingle), .count(sglCount));
  eccSatCounter #(.CNT_W(CNT_W)) uDblCnt (
    .clk(clk), .rstN(rstN), .clr(clrDbl), .inc(evtValid && evtDouble), .count(dblCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errLatched <= 1'b0;
      failAddr   <= '0;
    end else if (clrFail) begin
      errLatched <= 1'b0;
    end else if (evtValid && evtDouble && !errLatched) begin
      errLatched <= 1'b1;
      failAddr   <= evtAddr;
    end
  end

  always_comb begin
    sglWide = '0;
    dblWide = '0;
    sglWide[CNT_W-1:0] = sglCount;
    dblWide[CNT_W-1:0] = dblCount;
    case (cfgAddr)
      SEL_START: cfgRdata = winStart;
      SEL_END:   cfgRdata = winEnd;
      SEL_SGL:   cfgRdata = sglWide;
      SEL_DBL:   cfgRdata = dblWide;
      SEL_FAIL:  cfgRdata = failAddr;
      default:   cfgRdata = '0;
    endcase
  end
endmodule

// File: rtl/eccDatapath.sv
module eccDatapath
  import eccSecdedPkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  eccStrobe_t        strobe,
  input  logic              wrValid,
  input  logic [DATA_W-1:0] wrData,
  output logic              memValid,
  output logic [DATA_W-1:0] memData,
  output logic [LANE_W-1:0] memCheck,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  input  logic [LANE_W-1:0] rdCheck,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic [ADDR_W-1:0] outAddr,
  output logic              singleErr,
  output logic              doubleErr
);
  logic [LANE_W-1:0]     wrLane;
  logic [WIDE_HAM_W-1:0] rxHam, syn;
  logic                  rxOvr, parErr, synInRange, fixable, badWord;
  logic [DATA_W-1:0]     fixedData;

  always_comb begin
    wrLane = strobe.wrProtect ? encodeLane(wrData, strobe.narrow) : '0;
  end

  always_comb begin
    rxHam      = strobe.narrow ? {1'b0, rdCheck[NARROW_HAM_W-1:0]} : rdCheck[WIDE_HAM_W-1:0];
    rxOvr      = strobe.narrow ? rdCheck[NARROW_HAM_W] : rdCheck[WIDE_HAM_W];
    syn        = hamBits(rdData, strobe.narrow) ^ rxHam;
    parErr     = dataParity(rdData, strobe.narrow) ^ (^rxHam) ^ rxOvr;
    synInRange = int'(syn) <= (strobe.narrow ? NARROW_LAST_POS : WIDE_LAST_POS);
    fixable    = strobe.rdProtect && parErr && synInRange;
    badWord    = strobe.rdProtect && ((!parErr && syn != '0) || (parErr && !synInRange));
    fixedData  = fixable ? flipAt(rdData, syn, strobe.narrow) : rdData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memValid <= 1'b0;
      memData  <= '0;
      memCheck <= '0;
    end else begin
      memValid <= wrValid;
      if (wrValid) begin
        memData  <= wrData;
        memCheck <= wrLane;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outAddr   <= '0;
      singleErr <= 1'b0;
      doubleErr <= 1'b0;
    end else begin
      outValid  <= rdValid;
      singleErr <= rdValid && fixable;
      doubleErr <= rdValid && badWord;
      if (rdValid) begin
        outData <= fixedData;
        outAddr <= rdAddr;
      end
    end
  end
endmodule

// File: rtl/eccSecdedGuard.sv
module eccSecdedGuard
  import eccSecdedPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              narrowMode,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  output logic              memValid,
  output logic [31:0]       memData,
  output logic [7:0]        memCheck,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [31:0]       rdData,
  input  logic [7:0]        rdCheck,
  output logic              outValid,
  output logic [31:0]       outData,
  output logic              singleErr,
  output logic              doubleErr,
  input  logic              cfgWrite,
  input  logic [2:0]        cfgAddr,
  input  logic [ADDR_W-1:0] cfgWdata,
  output logic [ADDR_W-1:0] cfgRdata,
  output logic              errLatched
);
  eccStrobe_t        strobe;
  logic [ADDR_W-1:0] outAddr;
  logic [ADDR_W-1:0] failAddr;
  logic [CNT_W-1:0]  sglCount, dblCount;
  logic              wrHit, rdHit;

  assign wrHit = strobe.wrProtect;
  assign rdHit = strobe.rdProtect;

  eccControl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .narrowMode(narrowMode),
    .wrValid(wrValid), .wrAddr(wrAddr), .rdValid(rdValid), .rdAddr(rdAddr),
    .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .evtValid(outValid), .evtSingle(singleErr), .evtDouble(doubleErr), .evtAddr(outAddr),
    .strobe(strobe), .sglCount(sglCount), .dblCount(dblCount),
    .errLatched(errLatched), .failAddr(failAddr));

  eccDatapath #(.ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrValid(wrValid), .wrData(wrData),
    .memValid(memValid), .memData(memData), .memCheck(memCheck),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData), .rdCheck(rdCheck),
    .outValid(outValid), .outData(outData), .outAddr(outAddr),
    .singleErr(singleErr), .doubleErr(doubleErr));
endmodule

// File: rtl/eccSecdedGuardChk.sv
module eccSecdedGuardChk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              narrowMode,
  input logic              wrValid,
  input logic              wrHit,
  input logic              memValid,
  input logic [7:0]        memCheck,
  input logic              rdValid,
  input logic              rdHit,
  input logic [31:0]       rdData,
  input logic              outValid,
  input logic [31:0]       outData,
  input logic              singleErr,
  input logic              doubleErr,
  input logic [CNT_W-1:0]  sglCount,
  input logic [CNT_W-1:0]  dblCount,
  input logic              errLatched,
  input logic [ADDR_W-1:0] failAddr
);
  AST_LANE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> memCheck[7] == 1'b0);                                           // R1
  AST_NARROW_LANE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (memValid && $past(narrowMode)) |-> memCheck[7:6] == 2'b00);                 // R2
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(singleErr && doubleErr));                                                  // R4
  AST_FLAGS_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    (singleErr || doubleErr) |-> outValid);                                      // R10
  AST_OUT_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(rdValid));                                                // R10
  AST_BYPASS_READ: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdValid) && !$past(rdHit)) |->
      (outValid && outData == $past(rdData) && !singleErr && !doubleErr));       // R5
  AST_BYPASS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrValid) && !$past(wrHit)) |-> (memValid && memCheck == 8'h00));      // R5
  AST_SGL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (sglCount != $past(sglCount)) |->
      (sglCount == $past(sglCount) + 1'b1 || sglCount == '0));                   // R7
  AST_DBL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dblCount != $past(dblCount)) |->
      (dblCount == $past(dblCount) + 1'b1 || dblCount == '0));                   // R7
  AST_SGL_SATURATE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(sglCount) == '1) |-> (sglCount == '1 || sglCount == '0));             // R7
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ($past(errLatched) && errLatched) |-> failAddr == $past(failAddr));          // R9
endmodule

bind eccSecdedGuard eccSecdedGuardChk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .narrowMode(narrowMode), .wrValid(wrValid), .wrHit(wrHit),
  .memValid(memValid), .memCheck(memCheck), .rdValid(rdValid), .rdHit(rdHit),
  .rdData(rdData), .outValid(outValid), .outData(outData), .singleErr(singleErr),
  .doubleErr(doubleErr), .sglCount(sglCount), .dblCount(dblCount),
  .errLatched(errLatched), .failAddr(failAddr));

// File: tb/eccSecdedGuard_test.sv
module eccSecdedGuard_test;
  localparam int AW = 32;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic narrowMode = 1'b0;
  logic wrValid = 1'b0, rdValid = 1'b0, cfgWrite = 1'b0;
  logic [AW-1:0] wrAddr = '0, rdAddr = '0, cfgWdata = '0;
  logic [31:0] wrData = '0, rdData = '0;
  logic [7:0] rdCheck = '0;
  logic [2:0] cfgAddr = '0;
  logic memValid, outValid, singleErr, doubleErr, errLatched;
  logic [31:0] memData, outData;
  logic [7:0] memCheck;
  logic [AW-1:0] cfgRdata;

  int totalCnt = 0;
  int failCnt = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  eccSecdedGuard #(.ADDR_W(AW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .narrowMode(narrowMode),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .memValid(memValid), .memData(memData), .memCheck(memCheck),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData), .rdCheck(rdCheck),
    .outValid(outValid), .outData(outData), .singleErr(singleErr), .doubleErr(doubleErr),
    .cfgWrite(cfgWrite), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .errLatched(errLatched));

  // cls: 0 clean, 1 repaired, 2 unrepairable, 3 outside window
  typedef struct packed {
    logic        narrow;
    logic [31:0] addr;
    logic [31:0] data;
    logic [31:0] flipD;
    logic [7:0]  flipC;
    logic [1:0]  cls;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h100, 32'hA5A55A5A, 32'h0,        8'h00, 2'd0},
    '{1'b0, 32'h1FF, 32'hDEADBEEF, 32'h1,        8'h00, 2'd1},
    '{1'b0, 32'h150, 32'h12345678, 32'h80000000, 8'h00, 2'd1},
    '{1'b0, 32'h150, 32'hFFFFFFFF, 32'h0,        8'h01, 2'd1},
    '{1'b0, 32'h150, 32'h00000000, 32'h0,        8'h40, 2'd1},
    '{1'b0, 32'h150, 32'h13579BDF, 32'h00020008, 8'h00, 2'd2},
    '{1'b0, 32'h160, 32'h2468ACE0, 32'h00000020, 8'h04, 2'd2},
    '{1'b0, 32'h150, 32'hCAFEF00D, 32'h0,        8'h80, 2'd0},
    '{1'b1, 32'h120, 32'h0000BEEF, 32'h00008000, 8'h00, 2'd1},
    '{1'b1, 32'h120, 32'hABCD1234, 32'h00100000, 8'h00, 2'd0},
    '{1'b1, 32'h130, 32'h00007777, 32'h00000003, 8'h00, 2'd2},
    '{1'b1, 32'h120, 32'h00005555, 32'h0,        8'hC0, 2'd0},
    '{1'b1, 32'h120, 32'h0000FFFF, 32'h0,        8'h20, 2'd1},
    '{1'b0, 32'h0FF, 32'h11112222, 32'h00000010, 8'h00, 2'd3},
    '{1'b0, 32'h200, 32'h33334444, 32'h00000006, 8'h00, 2'd3}
  };

  function automatic logic [7:0] modelLane(logic [31:0] d, logic narrow);
    logic cw [64];
    logic [5:0] h;
    logic ovr;
    int n, r, k;
    n = narrow ? 16 : 32;
    r = narrow ? 5 : 6;
    k = 0;
    h = '0;
    for (int p = 0; p < 64; p++) cw[p] = 1'b0;
    for (int p = 1; p <= n + r; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < r; i++)
      for (int p = 1; p < 64; p++)
        if (((p >> i) & 1) == 1) h[i] = h[i] ^ cw[p];
    ovr = ^h;
    for (int j = 0; j < n; j++) ovr = ovr ^ d[j];
    return narrow ? {2'b00, ovr, h[4:0]} : {1'b0, ovr, h};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk);
    cfgWrite = 1'b1; cfgAddr = a; cfgWdata = v;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic cfgRd(input logic [2:0] a, output logic [31:0] v);
    cfgAddr = a;
    #1;
    v = cfgRdata;
  endtask

  // write then read back with flips; returns nothing, checks inline
  task automatic runBeat(input vec_t v, input string req);
    logic [7:0] lane, expLane;
    logic [31:0] rx, expData;
    logic expS, expD;
    @(negedge clk);
    narrowMode = v.narrow;
    wrValid = 1'b1; wrAddr = v.addr; wrData = v.data;
    @(negedge clk);
    wrValid = 1'b0;
    expLane = (v.cls == 2'd3) ? 8'h00 : modelLane(v.data, v.narrow);
    check(memValid === 1'b1, "R10", "memValid", {31'd0, memValid}, 32'd1);
    check(memData === v.data, req, "memData", memData, v.data);
    check(memCheck === expLane, v.narrow ? "R2" : "R1", "memCheck", {24'd0, memCheck},
          {24'd0, expLane});
    lane = memCheck;
    rx = v.data ^ v.flipD;
    rdValid = 1'b1; rdAddr = v.addr; rdData = rx; rdCheck = lane ^ v.flipC;
    @(negedge clk);
    rdValid = 1'b0;
    expS = (v.cls == 2'd1);
    expD = (v.cls == 2'd2);
    if (v.cls == 2'd3)  expData = rx;
    else if (v.narrow)  expData = {rx[31:16], v.data[15:0]};
    else                expData = v.data;
    check(outValid === 1'b1, "R10", "outValid", {31'd0, outValid}, 32'd1);
    check(singleErr === expS, req, "singleErr", {31'd0, singleErr}, {31'd0, expS});
    check(doubleErr === expD, req, "doubleErr", {31'd0, doubleErr}, {31'd0, expD});
    if (!expD) check(outData === expData, req, "outData", outData, expData);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      totalCnt++;
      failCnt++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    logic [31:0] rv;
    int expSgl, expDbl;
    logic [31:0] firstFail;
    bit haveFail;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    cfgRd(3'd0, rv); check(rv === 32'hFFFFFFFF, "R11", "winStart", rv, 32'hFFFFFFFF);
    cfgRd(3'd1, rv); check(rv === 32'h0, "R11", "winEnd", rv, 32'h0);
    cfgRd(3'd2, rv); check(rv === 32'h0, "R11", "sglCount", rv, 32'h0);
    cfgRd(3'd3, rv); check(rv === 32'h0, "R11", "dblCount", rv, 32'h0);
    check(errLatched === 1'b0, "R11", "errLatched", {31'd0, errLatched}, 32'd0);
    check(memValid === 1'b0 && outValid === 1'b0, "R11", "valids",
          {30'd0, memValid, outValid}, 32'd0);

    // R5 window is empty after reset: an in-range address is not coded
    begin
      vec_t bv;
      bv = '{1'b0, 32'h150, 32'h0F0F0F0F, 32'h00000001, 8'h00, 2'd3};
      runBeat(bv, "R5");
    end

    cfgWr(3'd0, 32'h100);
    cfgWr(3'd1, 32'h1FF);
    cfgRd(3'd0, rv); check(rv === 32'h100, "R8", "winStart readback", rv, 32'h100);
    cfgRd(3'd1, rv); check(rv === 32'h1FF, "R8", "winEnd readback", rv, 32'h1FF);

    expSgl = 0; expDbl = 0; haveFail = 0; firstFail = '0;
    for (int i = 0; i < NV; i++) begin
      string req;
      case (VECS[i].cls)
        2'd0: req = (VECS[i].flipC != 0) ? "R6" : (VECS[i].narrow ? "R2" : "R1");
        2'd1: req = "R3";
        2'd2: req = "R4";
        default: req = "R5";
      endcase
      runBeat(VECS[i], req);
      if (VECS[i].cls == 2'd1) expSgl++;
      if (VECS[i].cls == 2'd2) begin
        expDbl++;
        if (!haveFail) begin haveFail = 1; firstFail = VECS[i].addr; end
      end
    end

    cfgRd(3'd2, rv); check(rv === expSgl, "R7", "sglCount", rv, expSgl);
    cfgRd(3'd3, rv); check(rv === expDbl, "R7", "dblCount", rv, expDbl);
    cfgRd(3'd4, rv); check(rv === firstFail, "R9", "failAddr first", rv, firstFail);
    check(errLatched === 1'b1, "R9", "errLatched", {31'd0, errLatched}, 32'd1);

    // R7 saturation at all-ones (3-bit counter)
    begin
      vec_t sv;
      sv = '{1'b0, 32'h180, 32'h76543210, 32'h00000100, 8'h00, 2'd1};
      for (int j = 0; j < 3; j++) runBeat(sv, "R3");
    end
    cfgRd(3'd2, rv); check(rv === 32'd7, "R7", "sglCount saturated", rv, 32'd7);
    cfgRd(3'd3, rv); check(rv === expDbl, "R7", "dblCount unchanged", rv, expDbl);

    // R8 clear only the single counter
    cfgWr(3'd5, 32'h1);
    cfgRd(3'd2, rv); check(rv === 32'd0, "R8", "sglCount cleared", rv, 32'd0);
    cfgRd(3'd3, rv); check(rv === expDbl, "R8", "dblCount kept", rv, expDbl);
    check(errLatched === 1'b1, "R8", "latch kept", {31'd0, errLatched}, 32'd1);

    // R8 clear double counter and latch
    cfgWr(3'd5, 32'h6);
    cfgRd(3'd3, rv); check(rv === 32'd0, "R8", "dblCount cleared", rv, 32'd0);
    check(errLatched === 1'b0, "R8", "latch cleared", {31'd0, errLatched}, 32'd0);

    // R9 new first failure, second failure ignored
    begin
      vec_t d1, d2;
      d1 = '{1'b0, 32'h1A0, 32'h55AA55AA, 32'h00000C00, 8'h00, 2'd2};
      d2 = '{1'b1, 32'h1B0, 32'h00001111, 32'h00000201, 8'h00, 2'd2};
      runBeat(d1, "R4");
      runBeat(d2, "R4");
    end
    cfgRd(3'd4, rv); check(rv === 32'h1A0, "R9", "failAddr held", rv, 32'h1A0);
    cfgRd(3'd3, rv); check(rv === 32'd2, "R7", "dblCount after clear", rv, 32'd2);

    finished = 1;
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end
endmodule